// File: doc/BRIEF.md
# Interprocessor Interrupt Dispatch Unit

The block provides a small set of software-triggered interrupt channels that one processor uses to interrupt others. Each channel holds a configuration word with a vector, a priority, a mask bit and a read-only activity flag. Each channel also has a dispatch register. Writing a processor bitmask to it marks the channel pending on every selected processor at once, and each target keeps its own pending state.

The pending bits, gated by the channel mask, go to the per-processor presentation logic together with each channel's vector and priority. A processor takes a channel by acknowledging its vector, which moves that processor's pending bit into service. An end-of-interrupt from that processor then retires its highest-priority in-service channel. Software reaches the registers through a plain write/read port. Register address `2*ch` is the configuration word of channel `ch` and `2*ch+1` is its dispatch register.

Top module: `ipi_dispatch_unit`

## Requirements
- R1: After reset, channel `ch` is masked, has vector 0x40+ch and priority 10+ch, and is neither pending nor in service on any processor. For example, channel 2 reads 0x800C0042.
- R2: A write of bitmask `m` to the dispatch register of channel `ch` (address 2*ch+1, bit p selects processor p) sets the pending bit of `ch` on each processor whose bit is 1. `req_o[ch*NUM_CPU+p]` shows that bit from the next cycle while the channel is unmasked.
- R3: A dispatch write whose processor bitmask is zero changes no pending bit.
- R4: The mask bit (bit 31 of the configuration word) forces `req_o` of that channel to zero without discarding pending bits. Clearing the mask presents them again.
- R5: When processor p acknowledges (`ack_valid_i[p]` with `ack_vec_i` slice p) a vector equal to that of a channel pending on p, that channel's pending bit for p clears and its in-service bit for p sets. Other processors are unaffected.
- R6: A dispatch to a channel already pending on a processor merges into the existing bit, so a single acknowledge clears it.
- R7: The activity flag (bit 30 of the configuration word) reads 1 exactly when the channel is pending or in service on at least one processor.
- R8: A configuration write always updates the mask bit. It updates the vector (bits 7:0) and the priority (bits 19:16) only when, before the write, the channel was masked and its activity flag was 0.
- R9: `eoi_i[p]` clears the in-service bit on processor p of the in-service channel with the highest priority. On equal priority the lowest channel index is cleared.
- R10: A dispatch and an acknowledge of the same channel on the same processor in one cycle leave the channel pending there, and it also enters service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address: 2*ch configuration, 2*ch+1 dispatch |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for the addressed register; dispatch registers read 0 |
| ack_valid_i | input | NUM_CPU | Per-processor acknowledge strobe |
| ack_vec_i | input | NUM_CPU*VEC_W | Per-processor acknowledged vector |
| eoi_i | input | NUM_CPU | Per-processor end-of-interrupt strobe |
| req_o | output | NUM_CH*NUM_CPU | Presented pending bit, index ch*NUM_CPU+cpu |
| ch_vec_o | output | NUM_CH*VEC_W | Vector of each channel |
| ch_pri_o | output | NUM_CH*PRI_W | Priority of each channel |

## Verification
The hardest state to reach from the ports is a channel that is masked but still active. A processor must be left pending and a second one must hold the channel in service, and then a configuration write must arrive that the lock has to refuse. The directed sequence builds this state step by step. It then drains the channel with acknowledges and end-of-interrupts until the activity flag drops, and shows that the same write is then accepted. A constrained random phase then mixes dispatches, acknowledges aimed at the live vectors, end-of-interrupts and mask changes, so that many processors hold several channels in service at once and the end-of-interrupt order by priority is exercised widely.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int DATA_W   = 32;
  localparam int PRI_LSB  = 16;
  localparam int ACT_BIT  = 30;
  localparam int MASK_BIT = 31;
endpackage

// File: rtl/ipi_chan_regs.sv
module ipi_chan_regs import ipi_pkg::*; #(
  parameter int VEC_W = 8,
  parameter int PRI_W = 4,
  parameter logic [VEC_W-1:0] RST_VEC = '0,
  parameter logic [PRI_W-1:0] RST_PRI = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              active_i,
  output logic [VEC_W-1:0]  vec_o,
  output logic [PRI_W-1:0]  pri_o,
  output logic              mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= 1'b1;
      vec_o  <= RST_VEC;
      pri_o  <= RST_PRI;
    end else if (cfg_we_i) begin
      mask_o <= wdata_i[MASK_BIT];
      // vector/priority only change on a quiet, masked channel
      if (mask_o && !active_i) begin
        vec_o <= wdata_i[VEC_W-1:0];
        pri_o <= wdata_i[PRI_LSB +: PRI_W];
      end
    end
  end
endmodule

// File: rtl/ipi_pend_cell.sv
module ipi_pend_cell #(
  parameter int NUM_CPU = 4,
  parameter int VEC_W   = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     disp_we_i,
  input  logic [NUM_CPU-1:0]       disp_mask_i,
  input  logic [NUM_CPU-1:0]       ack_valid_i,
  input  logic [NUM_CPU*VEC_W-1:0] ack_vec_i,
  input  logic [NUM_CPU-1:0]       eoi_clr_i,
  input  logic [VEC_W-1:0]         vec_i,
  output logic [NUM_CPU-1:0]       pend_o,
  output logic [NUM_CPU-1:0]       insvc_o,
  output logic                     active_o
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic hit, set;
    assign hit = ack_valid_i[c] && (ack_vec_i[c*VEC_W +: VEC_W] == vec_i) && pend_o[c];
    assign set = disp_we_i && disp_mask_i[c];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_o[c]  <= 1'b0;
        insvc_o[c] <= 1'b0;
      end else begin
        pend_o[c]  <= (pend_o[c] && !hit) || set;
        insvc_o[c] <= (insvc_o[c] && !eoi_clr_i[c]) || hit;
      end
    end
  end

  assign active_o = |{pend_o, insvc_o};
endmodule

// File: rtl/ipi_eoi_sel.sv
module ipi_eoi_sel #(
  parameter int NUM_CH = 4,
  parameter int PRI_W  = 4
) (
  input  logic                    eoi_i,
  input  logic [NUM_CH-1:0]       insvc_i,
  input  logic [NUM_CH*PRI_W-1:0] pri_i,
  output logic [NUM_CH-1:0]       clr_o
);
  logic [NUM_CH-1:0] pick;
  logic [PRI_W-1:0]  best;
  logic              found;

  always_comb begin
    pick  = '0;
    best  = '0;
    found = 1'b0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      // strict compare keeps the lowest index on a tie
      if (insvc_i[ch] && (!found || pri_i[ch*PRI_W +: PRI_W] > best)) begin
        pick     = '0;
        pick[ch] = 1'b1;
        best     = pri_i[ch*PRI_W +: PRI_W];
        found    = 1'b1;
      end
    end
    clr_o = eoi_i ? pick : '0;
  end
endmodule

// File: rtl/ipi_dispatch_unit.sv
module ipi_dispatch_unit import ipi_pkg::*; #(
  parameter int NUM_CH   = 4,
  parameter int NUM_CPU  = 4,
  parameter int VEC_W    = 8,
  parameter int PRI_W    = 4,
  parameter int VEC_BASE = 64,
  parameter int PRI_BASE = 10,
  parameter int ADDR_W   = $clog2(NUM_CH) + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      reg_we_i,
  input  logic [ADDR_W-1:0]         reg_addr_i,
  input  logic [DATA_W-1:0]         reg_wdata_i,
  output logic [DATA_W-1:0]         reg_rdata_o,
  input  logic [NUM_CPU-1:0]        ack_valid_i,
  input  logic [NUM_CPU*VEC_W-1:0]  ack_vec_i,
  input  logic [NUM_CPU-1:0]        eoi_i,
  output logic [NUM_CH*NUM_CPU-1:0] req_o,
  output logic [NUM_CH*VEC_W-1:0]   ch_vec_o,
  output logic [NUM_CH*PRI_W-1:0]   ch_pri_o
);
  localparam int CH_W = ADDR_W - 1;
  localparam int NPAIR = NUM_CH * NUM_CPU;

  logic [CH_W-1:0]   ch_sel;
  logic              disp_sel;
  logic [NUM_CH-1:0] mask_vec;
  logic [NUM_CH-1:0] act_vec;
  logic [NPAIR-1:0]  pend_flat;
  logic [NPAIR-1:0]  insvc_flat;
  logic [NPAIR-1:0]  insvc_col;     // cpu-major
  logic [NPAIR-1:0]  eoi_clr_flat;  // cpu-major
  logic [NPAIR-1:0]  chan_clr;      // channel-major

  assign ch_sel   = reg_addr_i[ADDR_W-1:1];
  assign disp_sel = reg_addr_i[0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic cfg_we, disp_we;
    assign cfg_we  = reg_we_i && !disp_sel && (ch_sel == CH_W'(g));
    assign disp_we = reg_we_i &&  disp_sel && (ch_sel == CH_W'(g));

    ipi_chan_regs #(
      .VEC_W  (VEC_W),
      .PRI_W  (PRI_W),
      .RST_VEC(VEC_W'(VEC_BASE + g)),
      .RST_PRI(PRI_W'(PRI_BASE + g))
    ) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cfg_we_i(cfg_we),
      .wdata_i (reg_wdata_i),
      .active_i(act_vec[g]),
      .vec_o   (ch_vec_o[g*VEC_W +: VEC_W]),
      .pri_o   (ch_pri_o[g*PRI_W +: PRI_W]),
      .mask_o  (mask_vec[g])
    );

    ipi_pend_cell #(
      .NUM_CPU(NUM_CPU),
      .VEC_W  (VEC_W)
    ) u_pend (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .disp_we_i  (disp_we),
      .disp_mask_i(reg_wdata_i[NUM_CPU-1:0]),
      .ack_valid_i(ack_valid_i),
      .ack_vec_i  (ack_vec_i),
      .eoi_clr_i  (chan_clr[g*NUM_CPU +: NUM_CPU]),
      .vec_i      (ch_vec_o[g*VEC_W +: VEC_W]),
      .pend_o     (pend_flat[g*NUM_CPU +: NUM_CPU]),
      .insvc_o    (insvc_flat[g*NUM_CPU +: NUM_CPU]),
      .active_o   (act_vec[g])
    );

    assign req_o[g*NUM_CPU +: NUM_CPU] = mask_vec[g] ? '0 : pend_flat[g*NUM_CPU +: NUM_CPU];

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_x
      assign insvc_col[c*NUM_CH + g]  = insvc_flat[g*NUM_CPU + c];
      assign chan_clr[g*NUM_CPU + c]  = eoi_clr_flat[c*NUM_CH + g];
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_eoi
    ipi_eoi_sel #(
      .NUM_CH(NUM_CH),
      .PRI_W (PRI_W)
    ) u_sel (
      .eoi_i  (eoi_i[c]),
      .insvc_i(insvc_col[c*NUM_CH +: NUM_CH]),
      .pri_i  (ch_pri_o),
      .clr_o  (eoi_clr_flat[c*NUM_CH +: NUM_CH])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (!disp_sel && ch_sel == CH_W'(ch)) begin
        reg_rdata_o[MASK_BIT]             = mask_vec[ch];
        reg_rdata_o[ACT_BIT]              = act_vec[ch];
        reg_rdata_o[PRI_LSB +: PRI_W]     = ch_pri_o[ch*PRI_W +: PRI_W];
        reg_rdata_o[VEC_W-1:0]            = ch_vec_o[ch*VEC_W +: VEC_W];
      end
    end
  end
endmodule

// File: rtl/ipi_dispatch_unit_chk.sv
module ipi_dispatch_unit_chk #(
  parameter int NUM_CH  = 4,
  parameter int NUM_CPU = 4,
  parameter int VEC_W   = 8,
  parameter int PRI_W   = 4,
  parameter int ADDR_W  = 3
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      reg_we_i,
  input logic [ADDR_W-1:0]         reg_addr_i,
  input logic [NUM_CPU-1:0]        disp_data_i,
  input logic [NUM_CH*NUM_CPU-1:0] req_o,
  input logic [NUM_CH*VEC_W-1:0]   ch_vec_o,
  input logic [NUM_CH*PRI_W-1:0]   ch_pri_o,
  input logic [NUM_CH*NUM_CPU-1:0] pend_flat,
  input logic [NUM_CH-1:0]         mask_vec,
  input logic [NUM_CH-1:0]         act_vec,
  input logic [NUM_CH*NUM_CPU-1:0] eoi_clr_flat
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    AST_MASK_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mask_vec[g] |-> (req_o[g*NUM_CPU +: NUM_CPU] == '0)); // R4

    AST_ZERO_DISPATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && reg_addr_i == ADDR_W'(2*g+1) && disp_data_i == '0)
      |=> ((pend_flat[g*NUM_CPU +: NUM_CPU] & ~$past(pend_flat[g*NUM_CPU +: NUM_CPU])) == '0)); // R3

    AST_DISPATCH_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && reg_addr_i == ADDR_W'(2*g+1))
      |=> ((pend_flat[g*NUM_CPU +: NUM_CPU] & $past(disp_data_i)) == $past(disp_data_i))); // R2

    AST_CFG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && reg_addr_i == ADDR_W'(2*g) && !(mask_vec[g] && !act_vec[g]))
      |=> ($stable(ch_vec_o[g*VEC_W +: VEC_W]) && $stable(ch_pri_o[g*PRI_W +: PRI_W]))); // R8

    AST_ACTIVE_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_flat[g*NUM_CPU +: NUM_CPU] != '0) |-> act_vec[g]); // R7
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    AST_EOI_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(eoi_clr_flat[c*NUM_CH +: NUM_CH])); // R9
  end
endmodule

bind ipi_dispatch_unit ipi_dispatch_unit_chk #(
  .NUM_CH (NUM_CH),
  .NUM_CPU(NUM_CPU),
  .VEC_W  (VEC_W),
  .PRI_W  (PRI_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .disp_data_i (reg_wdata_i[NUM_CPU-1:0]),
  .req_o       (req_o),
  .ch_vec_o    (ch_vec_o),
  .ch_pri_o    (ch_pri_o),
  .pend_flat   (pend_flat),
  .mask_vec    (mask_vec),
  .act_vec     (act_vec),
  .eoi_clr_flat(eoi_clr_flat)
);

// File: tb/ipi_dispatch_unit_test.sv
module ipi_dispatch_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int NCPU = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [3:0]  ack_valid_i = '0;
  logic [31:0] ack_vec_i = '0;
  logic [3:0]  eoi_i = '0;
  logic [15:0] req_o;
  logic [31:0] ch_vec_o;
  logic [15:0] ch_pri_o;

  int total = 0;
  int bad = 0;

  ipi_dispatch_unit uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  logic       m_pend [NCH][NCPU];
  logic       m_ins  [NCH][NCPU];
  logic       m_mask [NCH];
  logic [7:0] m_vec  [NCH];
  logic [3:0] m_pri  [NCH];

  function automatic logic m_act(int ch);
    logic a = 1'b0;
    for (int c = 0; c < NCPU; c++) a |= m_pend[ch][c] | m_ins[ch][c];
    return a;
  endfunction

  function automatic int m_eoi_pick(int c);
    int sel = -1;
    for (int ch = 0; ch < NCH; ch++)
      if (m_ins[ch][c] && (sel < 0 || m_pri[ch] > m_pri[sel])) sel = ch;
    return sel;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int ch = 0; ch < NCH; ch++) begin
      m_mask[ch] = 1'b1;
      m_vec[ch]  = 8'(64 + ch);
      m_pri[ch]  = 4'(10 + ch);
      for (int c = 0; c < NCPU; c++) begin
        m_pend[ch][c] = 1'b0;
        m_ins[ch][c]  = 1'b0;
      end
    end
  endtask

  // called at a negedge; returns at the next negedge with the model committed
  task automatic cyc(logic we, logic [2:0] addr, logic [31:0] wd,
                     logic [3:0] av, logic [31:0] avec, logic [3:0] eoi);
    logic       n_pend [NCH][NCPU];
    logic       n_ins  [NCH][NCPU];
    logic       n_mask [NCH];
    logic [7:0] n_vec  [NCH];
    logic [3:0] n_pri  [NCH];
    int pick [NCPU];
    reg_we_i = we; reg_addr_i = addr; reg_wdata_i = wd;
    ack_valid_i = av; ack_vec_i = avec; eoi_i = eoi;
    for (int c = 0; c < NCPU; c++) pick[c] = eoi[c] ? m_eoi_pick(c) : -1;
    for (int ch = 0; ch < NCH; ch++) begin
      n_mask[ch] = m_mask[ch]; n_vec[ch] = m_vec[ch]; n_pri[ch] = m_pri[ch];
      if (we && addr == 3'(2*ch)) begin
        n_mask[ch] = wd[31];
        if (m_mask[ch] && !m_act(ch)) begin
          n_vec[ch] = wd[7:0];
          n_pri[ch] = wd[19:16];
        end
      end
      for (int c = 0; c < NCPU; c++) begin
        logic hit, set;
        hit = av[c] && avec[c*8 +: 8] == m_vec[ch] && m_pend[ch][c];
        set = we && addr == 3'(2*ch+1) && wd[c];
        n_pend[ch][c] = (m_pend[ch][c] && !hit) || set;
        n_ins[ch][c]  = (m_ins[ch][c] && pick[c] != ch) || hit;
      end
    end
    @(posedge clk_i);
    @(negedge clk_i);
    reg_we_i = 1'b0; ack_valid_i = '0; eoi_i = '0;
    m_pend = n_pend; m_ins = n_ins; m_mask = n_mask; m_vec = n_vec; m_pri = n_pri;
  endtask

  task automatic rd(int ch, output logic [31:0] d);
    reg_addr_i = 3'(2*ch);
    #1;
    d = reg_rdata_o;
  endtask

  task automatic check_all(string tag);
    logic [31:0] d;
    for (int ch = 0; ch < NCH; ch++) begin
      logic [3:0] er;
      for (int c = 0; c < NCPU; c++) er[c] = m_pend[ch][c] && !m_mask[ch];
      chk(tag, 32'(req_o[ch*4 +: 4]), 32'(er));
      chk(tag, 32'(ch_vec_o[ch*8 +: 8]), 32'(m_vec[ch]));
      chk(tag, 32'(ch_pri_o[ch*4 +: 4]), 32'(m_pri[ch]));
      rd(ch, d);
      chk(tag, d, {m_mask[ch], m_act(ch), 10'b0, m_pri[ch], 8'b0, m_vec[ch]});
    end
  endtask

  function automatic logic [31:0] cfgw(logic msk, int ch);
    return {msk, 11'b0, m_pri[ch], 8'b0, m_vec[ch]};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h1DC5);
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(2, d); chk("R1", d, 32'h800C0042);
    check_all("R1");

    // unmask all channels (quiet, so vec/pri rewrite is allowed)
    for (int ch = 0; ch < NCH; ch++) cyc(1, 3'(2*ch), cfgw(0, ch), 0, 0, 0);
    check_all("R4");

    // R2 dispatch to processors 0 and 2
    cyc(1, 3'd3, 32'h5, 0, 0, 0);
    chk("R2", 32'(req_o[7:4]), 32'h5);
    check_all("R2");

    // R3 zero bitmask
    cyc(1, 3'd5, 32'h0, 0, 0, 0);
    chk("R3", 32'(req_o[11:8]), 32'h0);
    check_all("R3");

    // R6 merge, then R5 acknowledge on processor 0 only
    cyc(1, 3'd3, 32'h5, 0, 0, 0);
    cyc(0, 0, 0, 4'b0001, {24'b0, 8'h41}, 0);
    chk("R6", 32'(req_o[7:4]), 32'h4);
    chk("R5", 32'(req_o[7:4]), 32'h4);
    check_all("R5");

    // R4 mask hides, unmask restores
    cyc(1, 3'd2, cfgw(1, 1), 0, 0, 0);
    chk("R4", 32'(req_o[7:4]), 32'h0);
    cyc(1, 3'd2, cfgw(0, 1), 0, 0, 0);
    chk("R4", 32'(req_o[7:4]), 32'h4);

    // R7 activity flag while active
    rd(1, d); chk("R7", 32'(d[30]), 32'h1);

    // R8 masked but active: vector/priority write refused
    cyc(1, 3'd2, cfgw(1, 1), 0, 0, 0);
    cyc(1, 3'd2, 32'h8005_0077, 0, 0, 0);
    rd(1, d); chk("R8", d, 32'hC00B0041);
    // drain: ack cpu2, eoi cpu0 and cpu2
    cyc(0, 0, 0, 4'b0100, {8'b0, 8'h41, 16'b0}, 0);
    cyc(0, 0, 0, 0, 0, 4'b0101);
    rd(1, d); chk("R7", 32'(d[30]), 32'h0);
    cyc(1, 3'd2, 32'h8005_0077, 0, 0, 0);
    rd(1, d); chk("R8", d, 32'h80050077);
    check_all("R8");
    cyc(1, 3'd2, 32'h000B_0041, 0, 0, 0);
    check_all("R8");

    // R9 channels 0 (pri 10) and 3 (pri 13) in service on processor 1
    cyc(1, 3'd1, 32'h2, 0, 0, 0);
    cyc(1, 3'd7, 32'h2, 0, 0, 0);
    cyc(0, 0, 0, 4'b0010, {16'b0, 8'h40, 8'b0}, 0);
    cyc(0, 0, 0, 4'b0010, {16'b0, 8'h43, 8'b0}, 0);
    cyc(0, 0, 0, 0, 0, 4'b0010);
    rd(3, d); chk("R9", 32'(d[30]), 32'h0);
    rd(0, d); chk("R9", 32'(d[30]), 32'h1);
    cyc(0, 0, 0, 0, 0, 4'b0010);
    check_all("R9");

    // R10 dispatch and acknowledge together
    cyc(1, 3'd1, 32'h8, 0, 0, 0);
    cyc(1, 3'd1, 32'h8, 4'b1000, {8'h40, 24'b0}, 0);
    chk("R10", 32'(req_o[3]), 32'h1);
    check_all("R10");

    // constrained random phase
    for (int i = 0; i < 3000; i++) begin
      logic        we;
      logic [2:0]  addr;
      logic [31:0] wd, avec;
      logic [3:0]  av, eo;
      we = ($urandom % 3) != 0;
      addr = 3'($urandom % 8);
      if (addr[0]) wd = 32'($urandom % 16);
      else wd = {1'(($urandom % 4) == 0), 11'b0, 4'($urandom), 8'b0,
                 8'h40 + 8'($urandom % 6)};
      av = 4'($urandom);
      avec = '0;
      for (int c = 0; c < NCPU; c++) avec[c*8 +: 8] = m_vec[$urandom % NCH];
      eo = (($urandom % 3) == 0) ? 4'($urandom) : 4'b0;
      cyc(we, addr, wd, av, avec, eo);
      check_all("R2/R5/R9");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule